// File: doc/BRIEF.md
# Glyph Store Access Port

This block gives a host controller access to a small on-chip memory of user-defined character patterns through a single register location. The serial host protocol sits outside. The block sees decoded read and write strobes for that location, with an 8-bit write bus and an 8-bit read bus. One internal address pointer selects the entry for every access. Bit 7 of the write data decides what a write means. When it is set, the write reloads the pointer. When it is clear, bits 6:0 are stored as a pattern entry at the pointer.

Each accepted data read or data write advances the pointer by one, but only inside a fixed address window of 0x80 to 0xF7. That window maps onto 120 memory entries, and entry index = pointer − 0x80. An access at the top address 0xF7 is still carried out. After it, the port locks, and further data accesses are dropped until the host reloads the pointer. A reload with a value above the window puts the pointer back at 0x80. Read data comes from a synchronous memory and appears one cycle after the read strobe, with a valid flag.

Top module: `glyph_store_port`

## Requirements
- R1: After reset the pointer is 0x80, the port is unlocked and rvalid_o is low, so a data write made straight after reset lands in entry 0.
- R2: A write with wdata_i[7]=0 while unlocked stores wdata_i[6:0] at the current pointer. If the pointer is below 0xF7, the write then advances the pointer by one.
- R3: A read while unlocked raises rvalid_o on the following cycle, with rdata_o = {1'b0, entry at the pointer}. If the pointer is below 0xF7, the read then advances the pointer by one. rvalid_o is low in every other cycle.
- R4: A write with a value from 0x80 to 0xF7 loads the pointer with exactly that value, so the next data access uses entry (value − 0x80).
- R5: A write with a value from 0xF8 to 0xFF sets the pointer to 0x80.
- R6: A data read or data write at pointer 0xF7 is carried out and locks the port. While the port is locked, data writes leave the memory unchanged and reads produce no rvalid_o.
- R7: Any pointer load (wdata_i[7]=1) clears the lock.
- R8: When wr_i and rd_i are high in the same cycle, only the write is handled. The read is ignored and produces no rvalid_o.
- R9: The pointer always stays within 0x80 to 0xF7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe for the glyph register |
| rd_i | input | 1 | Read strobe for the glyph register |
| wdata_i | input | 8 | Write data: bit 7 set = pointer load, clear = entry data |
| rvalid_o | output | 1 | Read data valid, one cycle after an accepted read |
| rdata_o | output | 8 | Read data, bit 7 always zero |

## Verification
The assertions assume the strobes are single-cycle qualified events with no bus stall, so each cycle with wr_i or rd_i high counts as exactly one access. They also assume that wdata_i matters only when wr_i is high. The bench drives strobes and data only at the falling edge and holds them for one full cycle. It mixes in-window loads, out-of-window loads, data writes, reads and collisions of the two strobes. It fills every entry before any random reads, so no read ever returns uninitialised memory.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  parameter int PTR_W = 8;
  parameter int DAT_W = 7;
  parameter logic [PTR_W-1:0] PTR_BASE = 8'h80;
  parameter logic [PTR_W-1:0] PTR_LAST = 8'hF7;
  parameter int DEPTH = int'(PTR_LAST) - int'(PTR_BASE) + 1;
  parameter int IDX_W = $clog2(DEPTH);
  typedef logic [PTR_W-1:0] ptr_t;
endpackage

// File: rtl/glyph_ptr.sv
module glyph_ptr
  import glyph_pkg::*;
#(
  parameter ptr_t BASE = PTR_BASE,
  parameter ptr_t LAST = PTR_LAST,
  parameter int   IW   = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [PTR_W-1:0] wdata_i,
  output logic          wacc_o,
  output logic          racc_o,
  output logic [IW-1:0] idx_o
);
  ptr_t ptr_q;
  logic lock_q;
  logic load, acc;
  ptr_t off;

  assign load   = wr_i & wdata_i[PTR_W-1];
  assign wacc_o = wr_i & ~wdata_i[PTR_W-1] & ~lock_q;
  assign racc_o = rd_i & ~wr_i & ~lock_q;  // write wins a collision
  assign acc    = wacc_o | racc_o;
  assign off    = ptr_q - BASE;
  assign idx_o  = off[IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= BASE;
      lock_q <= 1'b0;
    end else if (load) begin
      ptr_q  <= (wdata_i > LAST) ? BASE : wdata_i;
      lock_q <= 1'b0;
    end else if (acc) begin
      if (ptr_q == LAST) lock_q <= 1'b1;
      else               ptr_q  <= ptr_q + 1'b1;
    end
  end

  a_r9_ptr_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q >= BASE) && (ptr_q <= LAST));
  a_r5_bad_load_to_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i > LAST) |=> (ptr_q == BASE) && !lock_q);
  a_r6_lock_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !load) |=> lock_q && $stable(ptr_q));
  a_r6_lock_at_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && ptr_q == LAST && !load) |=> lock_q);
  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + 1'b1);
  a_r8_no_read_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !racc_o);
endmodule

// File: rtl/glyph_ram.sv
module glyph_ram #(
  parameter int DEPTH = 120,
  parameter int W     = 7,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/glyph_store_port.sv
module glyph_store_port
  import glyph_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [PTR_W-1:0] wdata_i,
  output logic             rvalid_o,
  output logic [PTR_W-1:0] rdata_o
);
  logic wacc, racc;
  logic [IDX_W-1:0] idx;
  logic [DAT_W-1:0] ram_q;
  logic rvalid_q;

  glyph_ptr u_ptr (
    .clk_i, .rst_ni, .wr_i, .rd_i, .wdata_i,
    .wacc_o(wacc), .racc_o(racc), .idx_o(idx)
  );

  glyph_ram #(.DEPTH(DEPTH), .W(DAT_W), .AW(IDX_W)) u_ram (
    .clk_i, .we_i(wacc), .re_i(racc), .addr_i(idx),
    .wdata_i(wdata_i[DAT_W-1:0]), .rdata_o(ram_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= racc;
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = {{(PTR_W-DAT_W){1'b0}}, ram_q};

  a_r3_valid_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(rd_i && !wr_i));
  a_r8_collision_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i) |=> !rvalid_o);
endmodule

// File: tb/glyph_store_port_bench.sv
`timescale 1ns/1ps
module glyph_store_port_bench;
  logic clk = 0, rst_n = 0, wr = 0, rd = 0;
  logic [7:0] wd = 0;
  logic rvalid;
  logic [7:0] rdata;
  int total = 0, bad = 0;
  bit done = 0;

  int m_ptr = 'h80;
  bit m_lock = 0;
  int m_mem [120];

  always #2.5 clk = ~clk;

  glyph_store_port u_glyph_store_port (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .wdata_i(wd),
    .rvalid_o(rvalid), .rdata_o(rdata)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model, compare at next negedge
  task automatic op(bit w, bit r, int d, string tag);
    bit ev = 0; int ed = 0;
    wr = w; rd = r; wd = d[7:0];
    if (w && d[7]) begin
      m_ptr = (d > 'hF7) ? 'h80 : d; m_lock = 0;
    end else if (w && !m_lock) begin
      m_mem[m_ptr-'h80] = d & 'h7F;
      if (m_ptr == 'hF7) m_lock = 1; else m_ptr++;
    end else if (!w && r && !m_lock) begin
      ev = 1; ed = m_mem[m_ptr-'h80];
      if (m_ptr == 'hF7) m_lock = 1; else m_ptr++;
    end
    @(negedge clk);
    wr = 0; rd = 0;
    check(rvalid == ev, {tag, " rvalid"}, rvalid, ev);
    if (ev) check(rdata == ed[7:0], {tag, " rdata"}, rdata, ed);
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (m_mem[i]) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    check(rvalid == 0, "R1 reset rvalid", rvalid, 0);
    rst_n = 1;
    @(negedge clk);
    op(1, 0, 'h11, "R1");
    op(1, 0, 'h80, "R4");
    op(0, 1, 0, "R1");
    // fill whole memory, last write locks (R2, R6)
    op(1, 0, 'h80, "R4");
    for (int i = 0; i < 120; i++) op(1, 0, (i ^ 'h55) & 'h7F, "R2");
    op(1, 0, 'h7F, "R6 locked write");
    op(0, 1, 0, "R6 locked read");
    op(1, 0, 'hF7, "R7");
    op(0, 1, 0, "R6 read at last");
    op(0, 1, 0, "R6 read after lock");
    op(1, 0, 'hF7, "R7");
    op(1, 0, 'h3C, "R6 write at last");
    op(1, 0, 'h01, "R6 ignored write");
    op(1, 0, 'hF7, "R7");
    op(0, 1, 0, "R6 ignored write kept");
    op(1, 0, 'hFA, "R5");
    op(0, 1, 0, "R5");
    op(1, 0, 'hFF, "R5");
    op(0, 1, 0, "R5");
    op(1, 0, 'hA0, "R4");
    for (int i = 0; i < 4; i++) op(0, 1, 0, "R3");
    op(1, 1, 'h2A, "R8");
    op(1, 1, 'hA0, "R8");
    op(0, 1, 0, "R8");
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      if (k < 2)      op(1, 0, $urandom_range('h80, 'hFF), "R4 R5 rand load");
      else if (k < 3) op(1, 0, $urandom_range('hF0, 'hF7), "R6 rand near last");
      else if (k < 5) op(1, 0, $urandom_range(0, 'h7F), "R2 rand write");
      else if (k < 9) op(0, 1, 0, "R3 rand read");
      else            op(1, 1, $urandom_range(0, 'hFF), "R8 rand both");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule